// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the card bus clock from the controller's source clock. A configuration write supplies a 2-bit rate mode, a divisor, a half-rate override and a clock-enable bit. The block turns these into a divide ratio, runs a free counter over that ratio, and drives `cardClk`. `cardClk` is a level that is high for the first half of every output period. When the ratio is 1 it stays high, which means the source clock passes through.

Whenever a write changes the mode, the divisor or the override, the divider restarts from the start of a period and `clkStable` drops. `clkStable` rises again once two full periods of the new clock have elapsed. Software keeps the clock gated off while it reprograms, polls `clkStable`, and then opens the gate. `ddrMode` tells downstream timeout logic that a double-data-rate mode is selected.

Top module: `sdck_gen`

## Requirements
- R1: With mode 1 and the override clear, the divide ratio is 1, and `cardClk` is high on every cycle while the clock is enabled.
- R2: With mode 0 and the override clear, divisor 0 gives ratio 2 and divisor N>0 gives ratio 4·N. Within each period of ratio R, `cardClk` is high for the first R/2 cycles, counted from the restart, and low for the rest.
- R3: With mode 2 or 3 and the override clear, divisor 0 gives ratio 4 and divisor N>0 gives ratio 4·N, with the same high-then-low waveform as R2.
- R4: With the half-rate override set, the ratio is 2 for every mode and every divisor value.
- R5: A written divisor larger than 2^DIV_W−1 is stored as 2^DIV_W−1. With DIV_W=8, a written value of 300 behaves as 255.
- R6: A write that changes the mode, the divisor or the override has these effects. At the write edge the period counter restarts, so `cardClk` is in its high phase in the following cycle when enabled. `clkStable` is low from that edge until exactly 2·R clock edges later, where R is the new ratio, and is high from then on.
- R7: A write that leaves the mode, the clamped divisor and the override unchanged does not restart the counter and does not disturb `clkStable`. Only the enable bit is taken from it.
- R8: While the enable bit is 0, `cardClk` is held low, and the period counter keeps its phase.
- R9: `ddrMode` is 1 exactly when the stored mode is 2 or 3. It reflects the new mode from the cycle after the write.
- R10: After reset the configuration is mode 0, divisor 0, override clear and clock disabled. `cardClk` and `ddrMode` are 0, and `clkStable` rises 4 edges after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| wrMode | input | 2 | Rate mode: 0 single-rate divided, 1 undivided, 2/3 double-rate divided |
| wrDiv | input | WR_W | Divisor value, clamped to DIV_W bits |
| wrHalf | input | 1 | Half-rate override, forces ratio 2 |
| wrClkOn | input | 1 | Clock enable; 0 gates `cardClk` low |
| cardClk | output | 1 | Card clock level |
| clkStable | output | 1 | Output settled after the last reprogram |
| ddrMode | output | 1 | Double-data-rate mode selected |

## Verification
The hardest cases to reach are the two kinds of write that touch nothing or only the enable bit. A write that changes no divider field must leave the phase and the stable flag alone. Gating must freeze the output while the counter runs on underneath. The bench reaches these cases with writes issued mid-period that repeat the stored mode and divisor and only flip the enable bit. It then compares every following cycle against a phase count that it keeps since the last restart, so a spurious restart or a stalled counter shows up as a phase error once the gate is reopened.

// File: rtl/sdck_pkg.sv
package sdck_pkg;
  // strobes from control to divider datapath
  typedef struct packed {
    logic restart;  // reload period counter to zero
    logic gateOn;   // allow the card clock out
  } sdckStrobe_t;
endpackage

// File: rtl/sdck_ctrl.sv
module sdck_ctrl
  import sdck_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int WR_W    = 16,
  parameter int RATIO_W = DIV_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         wrMode,
  input  logic [WR_W-1:0]    wrDiv,
  input  logic               wrHalf,
  input  logic               wrClkOn,
  input  logic               periodWrap,
  output logic [RATIO_W-1:0] ratio,
  output sdckStrobe_t        strobe,
  output logic               clkStable,
  output logic               ddrMode
);
  localparam logic [WR_W-1:0] DIV_MAX = WR_W'((1 << DIV_W) - 1);

  logic [1:0]       modeQ;
  logic [DIV_W-1:0] divQ;
  logic             halfQ;
  logic             clkOnQ;
  logic [1:0]       perCnt;
  logic             stableQ;
  logic [DIV_W-1:0] divClamped;
  logic             fieldsChanged;

  assign divClamped    = (wrDiv > DIV_MAX) ? DIV_MAX[DIV_W-1:0] : wrDiv[DIV_W-1:0];
  assign fieldsChanged = (modeQ != wrMode) || (divQ != divClamped) || (halfQ != wrHalf);

  assign strobe.restart = cfgWe && fieldsChanged;
  assign strobe.gateOn  = clkOnQ;

  always_comb begin
    if (halfQ) begin
      ratio = RATIO_W'(2);
    end else begin
      case (modeQ)
        2'd1:    ratio = RATIO_W'(1);
        2'd0:    ratio = (divQ == '0) ? RATIO_W'(2) : {divQ, 2'b00};
        default: ratio = (divQ == '0) ? RATIO_W'(4) : {divQ, 2'b00};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= 2'd0;
      divQ   <= '0;
      halfQ  <= 1'b0;
      clkOnQ <= 1'b0;
    end else if (cfgWe) begin
      modeQ  <= wrMode;
      divQ   <= divClamped;
      halfQ  <= wrHalf;
      clkOnQ <= wrClkOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt  <= 2'd0;
      stableQ <= 1'b0;
    end else if (strobe.restart) begin
      perCnt  <= 2'd0;
      stableQ <= 1'b0;
    end else if (periodWrap && !stableQ) begin
      perCnt <= perCnt + 2'd1;
      if (perCnt == 2'd1) stableQ <= 1'b1;
    end
  end

  assign clkStable = stableQ;
  assign ddrMode   = modeQ[1];
endmodule

// File: rtl/sdck_div.sv
module sdck_div
  import sdck_pkg::*;
#(
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratio,
  input  sdckStrobe_t        strobe,
  output logic               periodWrap,
  output logic               cardClk
);
  logic [RATIO_W-1:0] cnt;
  logic               highPhase;

  assign periodWrap = (cnt == ratio - RATIO_W'(1));
  assign highPhase  = (ratio == RATIO_W'(1)) || (cnt < (ratio >> 1));
  assign cardClk    = strobe.gateOn && highPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.restart) cnt <= '0;
    else if (periodWrap)     cnt <= '0;
    else                     cnt <= cnt + RATIO_W'(1);
  end
endmodule

// File: rtl/sdck_gen.sv
module sdck_gen
  import sdck_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int WR_W  = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [1:0]      wrMode,
  input  logic [WR_W-1:0] wrDiv,
  input  logic            wrHalf,
  input  logic            wrClkOn,
  output logic            cardClk,
  output logic            clkStable,
  output logic            ddrMode
);
  localparam int RATIO_W = DIV_W + 2;

  logic [RATIO_W-1:0] ratio;
  sdckStrobe_t        strobe;
  logic               periodWrap;

  sdck_ctrl #(.DIV_W(DIV_W), .WR_W(WR_W), .RATIO_W(RATIO_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .wrMode(wrMode), .wrDiv(wrDiv),
    .wrHalf(wrHalf), .wrClkOn(wrClkOn), .periodWrap(periodWrap),
    .ratio(ratio), .strobe(strobe), .clkStable(clkStable), .ddrMode(ddrMode)
  );

  sdck_div #(.RATIO_W(RATIO_W)) i_div (
    .clk(clk), .rstN(rstN), .ratio(ratio), .strobe(strobe),
    .periodWrap(periodWrap), .cardClk(cardClk)
  );
endmodule

// File: rtl/sdck_gen_chk.sv
module sdck_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [1:0] wrMode,
  input logic       wrClkOn,
  input logic       restart,
  input logic       gateOn,
  input logic       halfQ,
  input logic [1:0] modeQ,
  input logic       cardClk,
  input logic       clkStable,
  input logic       ddrMode
);
  AST_STABLE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !clkStable); // R6

  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (restart && wrClkOn) |=> cardClk); // R6

  AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |-> !cardClk); // R8

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (gateOn && !halfQ && modeQ == 2'd1) |-> cardClk); // R1

  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (halfQ && gateOn && !cfgWe) |=> (cardClk != $past(cardClk))); // R4

  AST_DDR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (ddrMode == ($past(wrMode) >= 2'd2))); // R9

  AST_STABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (clkStable && !restart) |=> clkStable); // R7
endmodule

bind sdck_gen sdck_gen_chk i_sdck_gen_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .wrMode(wrMode), .wrClkOn(wrClkOn),
  .restart(strobe.restart), .gateOn(strobe.gateOn),
  .halfQ(i_ctrl.halfQ), .modeQ(i_ctrl.modeQ),
  .cardClk(cardClk), .clkStable(clkStable), .ddrMode(ddrMode)
);

// File: tb/test_sdck_gen.sv
module test_sdck_gen;
  localparam int DIV_W = 8;
  localparam int WR_W  = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cfgWe = 1'b0;
  logic [1:0]      wrMode = 2'd0;
  logic [WR_W-1:0] wrDiv = '0;
  logic            wrHalf = 1'b0;
  logic            wrClkOn = 1'b0;
  logic            cardClk, clkStable, ddrMode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  int mMode = 0, mDiv = 0, mHalf = 0, mOn = 0;
  int j = 0;

  always #2 clk = ~clk;

  sdck_gen #(.DIV_W(DIV_W), .WR_W(WR_W)) i_sdck_gen (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .wrMode(wrMode), .wrDiv(wrDiv),
    .wrHalf(wrHalf), .wrClkOn(wrClkOn), .cardClk(cardClk),
    .clkStable(clkStable), .ddrMode(ddrMode)
  );

  function automatic int ratioOf(int md, int dv, int hf);
    if (hf != 0) return 2;
    if (md == 1) return 1;
    if (dv == 0) return (md == 0) ? 2 : 4;
    return 4 * dv;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      j = 0; mMode = 0; mDiv = 0; mHalf = 0; mOn = 0;
    end else begin
      int cd;
      cd = (int'(wrDiv) > 255) ? 255 : int'(wrDiv);
      if (cfgWe && (int'(wrMode) != mMode || cd != mDiv || int'(wrHalf) != mHalf)) begin
        j = 0;
      end else begin
        j = j + 1;
      end
      if (cfgWe) begin
        mMode = int'(wrMode); mDiv = cd; mHalf = int'(wrHalf); mOn = int'(wrClkOn);
      end
    end
  end

  task automatic checkCycles(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int r;
      bit eCk, eSt, eDdr;
      @(negedge clk);
      r = ratioOf(mMode, mDiv, mHalf);
      eCk  = (mOn != 0) && (r == 1 || (j % r) < r / 2);
      eSt  = (j >= 2 * r);
      eDdr = (mMode >= 2);
      total += 3;
      if (cardClk !== eCk) begin
        bad++;
        $display("FAIL %s cardClk j=%0d r=%0d actual=%b expected=%b", tag, j, r, cardClk, eCk);
      end
      if (clkStable !== eSt) begin
        bad++;
        $display("FAIL R6 clkStable j=%0d r=%0d actual=%b expected=%b", j, r, clkStable, eSt);
      end
      if (ddrMode !== eDdr) begin
        bad++;
        $display("FAIL R9 ddrMode actual=%b expected=%b", ddrMode, eDdr);
      end
    end
  endtask

  task automatic writeCfg(input int md, input int dv, input int hf, input int on);
    @(negedge clk);
    wrMode = 2'(md); wrDiv = WR_W'(dv); wrHalf = hf[0]; wrClkOn = on[0];
    cfgWe = 1'b1;
    @(posedge clk);
    #1 cfgWe = 1'b0;
  endtask

  initial begin
    #600000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkCycles(8, "R10");
    // R7: same fields, only enable changes
    writeCfg(0, 0, 0, 1);
    checkCycles(8, "R7");
    // R2 sweep of single-rate divisors
    for (int d = 0; d <= 5; d++) begin
      writeCfg(0, d, 0, 1);
      checkCycles(3 * ratioOf(0, d, 0) + 2, "R2");
    end
    writeCfg(0, 255, 0, 1);
    checkCycles(3 * 1020, "R2");
    // R1 pass-through
    writeCfg(1, 9, 0, 1);
    checkCycles(10, "R1");
    // R3 double-rate sweep
    for (int d = 0; d <= 3; d++) begin
      writeCfg(2, d, 0, 1);
      checkCycles(3 * ratioOf(2, d, 0) + 2, "R3");
    end
    writeCfg(3, 2, 0, 1);
    checkCycles(30, "R3");
    // R4 half-rate override across modes
    for (int m = 0; m < 4; m++) begin
      writeCfg(m, 7 + m, 1, 1);
      checkCycles(10, "R4");
    end
    // R5 clamp
    writeCfg(0, 300, 0, 1);
    checkCycles(3 * 1020, "R5");
    writeCfg(0, 255, 0, 1);  // equal after clamp: no restart
    checkCycles(20, "R5");
    // R8 gating with phase preserved, then R7 reopen mid-period
    writeCfg(0, 3, 0, 1);
    checkCycles(5, "R8");
    writeCfg(0, 3, 0, 0);
    checkCycles(27, "R8");
    writeCfg(0, 3, 0, 1);
    checkCycles(30, "R7");
    // R6 mid-period reprogram
    writeCfg(2, 1, 0, 1);
    checkCycles(3, "R6");
    writeCfg(0, 2, 0, 1);
    checkCycles(30, "R6");
    writeCfg(0, 2, 1, 1);
    checkCycles(8, "R6");
    // reset again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkCycles(8, "R10");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule